// File: doc/BRIEF.md
# Ping-pong DMA transfer channel

This block is one channel of a DMA engine. It moves single data items between a peripheral data register and a dual-port DMA RAM. The channel has no CPU bus interface of its own. Software sets a block of level configuration inputs and then pulses `cfg_arm`. From then on, each pulse on the selected request line, or on the software force input, moves one item in one cycle. The item is a byte or a 16-bit word, and it moves from the peripheral into RAM or from RAM out to the peripheral.

The RAM address can advance after every item, stay fixed, or come from an index that the peripheral supplies on top of the buffer base. The block length is programmable. The channel can stop after one block or run on indefinitely. It can also alternate between two buffers, so that one fills while software drains the other. The channel raises a one-cycle interrupt at the end of a block or, if selected, at its midpoint.

The CPU may write the same RAM location or peripheral register that the channel is writing in the same cycle. In that case the channel drops its own write, raises a sticky error and halts until software clears the error. It then repeats the same item.

Top module: `dma_pingpong_chan`

## Requirements
- R1: After reset `chan_on`, `irq`, `err`, `ram_we` and `per_we` are low. Request pulses have no effect until `cfg_arm` has been pulsed. A request seen in cycle c produces its transfer strobes in cycle c+1.
- R2: With `cfg_amode`=00 (post-increment), item k of a block goes to start address + k·2 for words. In continuous mode (`cfg_mode`=00) the address returns to the start address after item `cfg_cnt` (a block holds `cfg_cnt`+1 items), and `chan_on` stays high.
- R3: With `cfg_byte`=1 the address steps by 1. `ram_be` is 01 for an even byte address and 10 for an odd one, and the low byte of `per_rdata` is placed on both lanes of `ram_wdata`. Word transfers drive `ram_be`=11.
- R4: `cfg_dir`=0 reads the peripheral (`per_re`) and writes RAM (`ram_we`). `cfg_dir`=1 reads RAM (`ram_re`) and writes the peripheral (`per_we`). A byte read from RAM comes from the lane that address bit 0 selects and is zero-extended.
- R5: With `cfg_amode`=01 (also 11) every item of the block uses the start address.
- R6: With `cfg_amode`=10 the address is start + `per_idx` for bytes and start + 2·`per_idx` for words.
- R7: `cfg_mode` bit 0 set and bit 1 clear (one-shot) clears `chan_on` after the last item of the block. Later requests then move nothing.
- R8: `cfg_mode` bit 1 (ping-pong) makes successive blocks use `cfg_sta` and `cfg_stb` in turn. `buf_act` shows the buffer in use: 0 for A, 1 for B.
- R9: Only the request line numbered by `cfg_sel` (5 bits, 32 lines) starts a transfer. A `cfg_force` pulse also starts one.
- R10: `irq` pulses for one cycle, one cycle after the transfer strobes of the last item of a block. When `cfg_half`=1 it pulses instead after item number `cfg_cnt`>>1 (counting from 0) and not at the block end.
- R11: A collision occurs when the CPU writes the same RAM word with an overlapping byte lane, or writes the peripheral, in the same cycle as the channel's write. The channel's write is then suppressed, `err` sets, and no transfer happens while `err` is high. After `err_clr` the same item is repeated in the next cycle.
- R12: `irq` is never high while `err` is high. The interrupt of a collided block-end item appears only after its retry.
- R13: `cfg_mode`=11 (one-shot ping-pong) runs one block in buffer A and one block in buffer B, then clears `chan_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_arm | input | 1 | Pulse: enable channel, rewind count, address and buffer |
| cfg_dir | input | 1 | 0 peripheral to RAM, 1 RAM to peripheral |
| cfg_byte | input | 1 | 1 byte items, 0 word items |
| cfg_amode | input | 2 | 00 post-increment, 01/11 fixed, 10 peripheral-indexed |
| cfg_mode | input | 2 | bit 0 one-shot, bit 1 ping-pong |
| cfg_half | input | 1 | Interrupt at block midpoint instead of end |
| cfg_cnt | input | CW | Last item index of a block |
| cfg_sta | input | AW | Buffer A start byte address |
| cfg_stb | input | AW | Buffer B start byte address |
| cfg_sel | input | SW | Request line select |
| cfg_force | input | 1 | Software start of one item |
| err_clr | input | 1 | Clears the collision error |
| req | input | NSRC | Peripheral request pulses |
| per_idx | input | PIW | Peripheral-supplied address index |
| per_rdata | input | 16 | Peripheral read data |
| per_re | output | 1 | Peripheral read strobe |
| per_we | output | 1 | Peripheral write strobe |
| per_wdata | output | 16 | Peripheral write data |
| cpu_per_we | input | 1 | CPU writes the peripheral register this cycle |
| ram_addr | output | AW | RAM byte address |
| ram_be | output | 2 | RAM byte lanes |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, same cycle |
| cpu_ram_we | input | 1 | CPU writes the DMA RAM this cycle |
| cpu_ram_waddr | input | AW-1 | CPU RAM word address |
| cpu_ram_be | input | 2 | CPU RAM byte lanes |
| irq | output | 1 | Block or half-block interrupt pulse |
| err | output | 1 | Sticky collision error |
| chan_on | output | 1 | Channel enabled |
| buf_act | output | 1 | Active ping-pong buffer |

## Verification
The bench sweeps all 32 request lines against one selected line. A decoder that is off by one, or that ORs the lines together, would move data on the wrong pulses. Two blocks are run back to back in continuous mode, and the first block's words are read back through the RAM-to-peripheral direction. A missed reload would write past the buffer and return the wrong words. Collisions are forced on the block-end item, on the other word, on the other byte lane and on the peripheral. A design that compares addresses only at word granularity would trap on a disjoint lane. One that advances on a collided item would lose a word, and one that lets the interrupt out early would pulse `irq` while `err` is high. One-shot ping-pong checks that the channel stops after buffer B and not after buffer A.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      AM_INC  = 2'b00,
      AM_FIX  = 2'b01,
      AM_PIND = 2'b10,
      AM_FIX2 = 2'b11
   } amode_e;

   // byte lanes touched by one item
   function automatic logic [1:0] lane_mask(input logic byte_sz, input logic a0);
      return byte_sz ? (a0 ? 2'b10 : 2'b01) : 2'b11;
   endfunction

endpackage

// File: rtl/dmach_trig.sv
module dmach_trig #(
   parameter  int NSRC = 32,
   localparam int SW   = $clog2(NSRC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req,
   input  logic [SW-1:0]   sel,
   input  logic            force_i,
   input  logic            arm,
   input  logic            armed,
   input  logic            take,
   output logic            pend
);

   initial begin : param_chk
      if ((1 << SW) != NSRC) $fatal(1, "NSRC must be a power of two");
   end

   logic [NSRC-1:0] hit;
   logic            fire;

   for (genvar i = 0; i < NSRC; i++) begin : g_dec
      assign hit[i] = req[i] && (sel == SW'(i));
   end

   assign fire = armed && ((|hit) || force_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend <= 1'b0;
      else if (arm) pend <= 1'b0;
      else          pend <= (pend && !take) || fire;
   end

   // R9
   trig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(armed && (req[sel] || force_i)));

endmodule

// File: rtl/dmach_count.sv
module dmach_count #(
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic          adv,
   input  logic [CW-1:0] limit,
   output logic          last,
   output logic          half_hit
);

   initial begin : param_chk
      if (CW < 2 || CW > 16) $fatal(1, "CW out of range");
   end

   logic [CW-1:0] cnt;

   assign last     = (cnt == limit);
   assign half_hit = (cnt == (limit >> 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (arm) cnt <= '0;
      else if (adv) cnt <= last ? '0 : cnt + 1'b1;
   end

   // R2
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && last && !arm) |=> (cnt == '0));

endmodule

// File: rtl/dmach_addr.sv
module dmach_addr
   import dmach_pkg::*;
#(
   parameter int AW       = 11,
   parameter int PIW      = 4,
   parameter bit HAS_PIND = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           arm,
   input  logic           adv,
   input  logic           last,
   input  logic           size_byte,
   input  logic [1:0]     amode,
   input  logic           pingpong,
   input  logic [AW-1:0]  sta,
   input  logic [AW-1:0]  stb,
   input  logic [PIW-1:0] pidx,
   output logic [AW-1:0]  addr,
   output logic           buf_sel
);

   initial begin : param_chk
      if (PIW >= AW) $fatal(1, "PIW must be below AW");
   end

   amode_e        am;
   logic [AW-1:0] off_q;
   logic [AW-1:0] base;
   logic [AW-1:0] pind_off;

   assign am   = amode_e'(amode);
   assign base = buf_sel ? stb : sta;

   if (HAS_PIND) begin : g_pind
      logic [AW-1:0] idx_ext;
      assign idx_ext  = {{(AW-PIW){1'b0}}, pidx};
      assign pind_off = size_byte ? idx_ext : (idx_ext << 1);
   end else begin : g_nopind
      assign pind_off = '0;
   end

   always_comb begin
      unique case (am)
         AM_INC:  addr = base + off_q;
         AM_PIND: addr = base + pind_off;
         default: addr = base;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q   <= '0;
         buf_sel <= 1'b0;
      end else if (arm) begin
         off_q   <= '0;
         buf_sel <= 1'b0;
      end else if (adv) begin
         if (last) begin
            off_q <= '0;
            if (pingpong) buf_sel <= !buf_sel;
         end else if (am == AM_INC) begin
            off_q <= off_q + (size_byte ? AW'(1) : AW'(2));
         end
      end
   end

   // R8
   buf_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_sel != $past(buf_sel)) |-> ($past(arm) || $past(adv && last && pingpong)));

endmodule

// File: rtl/dma_pingpong_chan.sv
module dma_pingpong_chan
   import dmach_pkg::*;
#(
   parameter  int AW       = 11,
   parameter  int CW       = 10,
   parameter  int NSRC     = 32,
   parameter  int PIW      = 4,
   parameter  bit HAS_PIND = 1'b1,
   localparam int SW       = $clog2(NSRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_arm,
   input  logic              cfg_dir,
   input  logic              cfg_byte,
   input  logic [1:0]        cfg_amode,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_half,
   input  logic [CW-1:0]     cfg_cnt,
   input  logic [AW-1:0]     cfg_sta,
   input  logic [AW-1:0]     cfg_stb,
   input  logic [SW-1:0]     cfg_sel,
   input  logic              cfg_force,
   input  logic              err_clr,
   input  logic [NSRC-1:0]   req,
   input  logic [PIW-1:0]    per_idx,
   input  logic [WORD_W-1:0] per_rdata,
   output logic              per_re,
   output logic              per_we,
   output logic [WORD_W-1:0] per_wdata,
   input  logic              cpu_per_we,
   output logic [AW-1:0]     ram_addr,
   output logic [1:0]        ram_be,
   output logic              ram_re,
   output logic              ram_we,
   output logic [WORD_W-1:0] ram_wdata,
   input  logic [WORD_W-1:0] ram_rdata,
   input  logic              cpu_ram_we,
   input  logic [AW-2:0]     cpu_ram_waddr,
   input  logic [1:0]        cpu_ram_be,
   output logic              irq,
   output logic              err,
   output logic              chan_on
   ,output logic             buf_act
);

   initial begin : param_chk
      if (AW < 4 || AW > 24) $fatal(1, "AW out of range");
   end

   logic          pend, xfer, adv, last, half_hit, fin, irq_hit;
   logic          dma_ram_wr, dma_per_wr, coll_ram, coll_per, coll;
   logic          on_q, err_q, irq_q, buf_sel;
   logic          one_shot, ping;
   logic [AW-1:0] addr;
   logic [1:0]    lanes;
   logic [7:0]    rd_byte;

   assign one_shot = cfg_mode[0];
   assign ping     = cfg_mode[1];

   dmach_trig #(.NSRC(NSRC)) u_trig (
      .clk(clk), .rst_n(rst_n), .req(req), .sel(cfg_sel), .force_i(cfg_force),
      .arm(cfg_arm), .armed(on_q), .take(adv), .pend(pend)
   );

   dmach_count #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .arm(cfg_arm), .adv(adv), .limit(cfg_cnt),
      .last(last), .half_hit(half_hit)
   );

   dmach_addr #(.AW(AW), .PIW(PIW), .HAS_PIND(HAS_PIND)) u_addr (
      .clk(clk), .rst_n(rst_n), .arm(cfg_arm), .adv(adv), .last(last),
      .size_byte(cfg_byte), .amode(cfg_amode), .pingpong(ping),
      .sta(cfg_sta), .stb(cfg_stb), .pidx(per_idx), .addr(addr), .buf_sel(buf_sel)
   );

   // one item per cycle while a request waits and no error stands
   assign xfer       = pend && on_q && !err_q;
   assign dma_ram_wr = xfer && !cfg_dir;
   assign dma_per_wr = xfer && cfg_dir;
   assign lanes      = lane_mask(cfg_byte, addr[0]);

   assign coll_ram = dma_ram_wr && cpu_ram_we && (cpu_ram_waddr == addr[AW-1:1])
                     && ((cpu_ram_be & lanes) != 2'b00);
   assign coll_per = dma_per_wr && cpu_per_we;
   assign coll     = coll_ram || coll_per;
   assign adv      = xfer && !coll;
   assign fin      = adv && last && one_shot && (!ping || buf_sel);
   assign irq_hit  = cfg_half ? half_hit : last;

   assign rd_byte  = addr[0] ? ram_rdata[15:8] : ram_rdata[7:0];

   assign ram_addr  = addr;
   assign ram_be    = lanes;
   assign ram_re    = dma_per_wr && !coll;
   assign ram_we    = dma_ram_wr && !coll;
   assign ram_wdata = cfg_byte ? {2{per_rdata[7:0]}} : per_rdata;
   assign per_re    = dma_ram_wr && !coll;
   assign per_we    = dma_per_wr && !coll;
   assign per_wdata = cfg_byte ? {8'h00, rd_byte} : ram_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q  <= 1'b0;
         err_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (cfg_arm)  on_q <= 1'b1;
         else if (fin) on_q <= 1'b0;
         if (coll)         err_q <= 1'b1;
         else if (err_clr) err_q <= 1'b0;
         irq_q <= adv && irq_hit;
      end
   end

   assign irq     = irq_q;
   assign err     = err_q;
   assign chan_on = on_q;
   assign buf_act = buf_sel;

   // R11
   ram_coll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ram_we && ram_we) |->
         ((cpu_ram_waddr != ram_addr[AW-1:1]) || ((cpu_ram_be & ram_be) == 2'b00)));

   // R11
   per_coll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_per_we && per_we));

   // R11
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !err_clr) |=> err);

   // R11
   err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !(ram_we || per_we));

   // R12
   err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !irq);

   // R7
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !cfg_arm) |=> !chan_on);

endmodule

// File: tb/sim_dma_pingpong_chan.sv
`timescale 1ns/1ps
module sim_dma_pingpong_chan;

   localparam int AW = 11;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_arm, cfg_dir, cfg_byte, cfg_half, cfg_force, err_clr;
   logic [1:0]  cfg_amode, cfg_mode;
   logic [9:0]  cfg_cnt;
   logic [10:0] cfg_sta, cfg_stb;
   logic [4:0]  cfg_sel;
   logic [31:0] req;
   logic [3:0]  per_idx;
   logic [15:0] per_rdata, per_wdata, ram_wdata, ram_rdata;
   logic        per_re, per_we, cpu_per_we, ram_re, ram_we, cpu_ram_we;
   logic [10:0] ram_addr;
   logic [1:0]  ram_be, cpu_ram_be;
   logic [9:0]  cpu_ram_waddr;
   logic        irq, err, chan_on, buf_act;

   logic [15:0] mem [0:1023];

   int checks = 0;
   int errors = 0;
   int cur_sel = 5;

   logic        c_ram_we, c_per_we, c_irq, c_err, c_on, c_buf, c_we3;
   logic [10:0] c_addr;
   logic [1:0]  c_be;
   logic [15:0] c_wdata, c_pdata;

   always #2.5 clk = ~clk;

   dma_pingpong_chan u0 (
      .clk(clk), .rst_n(rst_n), .cfg_arm(cfg_arm), .cfg_dir(cfg_dir), .cfg_byte(cfg_byte),
      .cfg_amode(cfg_amode), .cfg_mode(cfg_mode), .cfg_half(cfg_half), .cfg_cnt(cfg_cnt),
      .cfg_sta(cfg_sta), .cfg_stb(cfg_stb), .cfg_sel(cfg_sel), .cfg_force(cfg_force),
      .err_clr(err_clr), .req(req), .per_idx(per_idx), .per_rdata(per_rdata),
      .per_re(per_re), .per_we(per_we), .per_wdata(per_wdata), .cpu_per_we(cpu_per_we),
      .ram_addr(ram_addr), .ram_be(ram_be), .ram_re(ram_re), .ram_we(ram_we),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .cpu_ram_we(cpu_ram_we),
      .cpu_ram_waddr(cpu_ram_waddr), .cpu_ram_be(cpu_ram_be), .irq(irq), .err(err),
      .chan_on(chan_on), .buf_act(buf_act)
   );

   // RAM model: same-cycle read, byte-lane write
   assign ram_rdata = mem[ram_addr[AW-1:1]];
   always @(posedge clk) begin
      if (ram_we) begin
         if (ram_be[0]) mem[ram_addr[AW-1:1]][7:0]  <= ram_wdata[7:0];
         if (ram_be[1]) mem[ram_addr[AW-1:1]][15:8] <= ram_wdata[15:8];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic arm(input bit dir, input bit byt, input logic [1:0] am, input logic [1:0] md,
                      input bit half, input int cnt, input int sta, input int stb, input int sel);
      @(negedge clk);
      cfg_dir = dir; cfg_byte = byt; cfg_amode = am; cfg_mode = md; cfg_half = half;
      cfg_cnt = 10'(cnt); cfg_sta = 11'(sta); cfg_stb = 11'(stb); cfg_sel = 5'(sel);
      cur_sel = sel; cfg_arm = 1'b1;
      @(negedge clk);
      cfg_arm = 1'b0;
   endtask

   // request (or force) in cycle 1, strobes sampled in cycle 2, flags in cycle 3
   task automatic xfer(input int src, input bit frc, input bit crw, input int cwaddr,
                       input logic [1:0] cbe, input bit cpw);
      @(negedge clk);
      req = '0;
      if (src >= 0) req[src] = 1'b1;
      cfg_force = frc; cpu_ram_we = crw; cpu_ram_waddr = 10'(cwaddr);
      cpu_ram_be = cbe; cpu_per_we = cpw;
      @(negedge clk);
      req = '0; cfg_force = 1'b0;
      c_ram_we = ram_we; c_per_we = per_we; c_addr = ram_addr; c_be = ram_be;
      c_wdata = ram_wdata; c_pdata = per_wdata;
      @(negedge clk);
      c_we3 = ram_we | per_we;
      c_irq = irq; c_err = err; c_on = chan_on; c_buf = buf_act;
      cpu_ram_we = 1'b0; cpu_per_we = 1'b0;
   endtask

   task automatic go();
      xfer(cur_sel, 1'b0, 1'b0, 0, 2'b00, 1'b0);
   endtask

   task automatic clr_err();
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_arm = 0; cfg_dir = 0; cfg_byte = 0; cfg_half = 0; cfg_force = 0;
      err_clr = 0; cfg_amode = 0; cfg_mode = 0; cfg_cnt = 0; cfg_sta = 0; cfg_stb = 0;
      cfg_sel = 5; req = '0; per_idx = 0; per_rdata = 0; cpu_per_we = 0; cpu_ram_we = 0;
      cpu_ram_waddr = 0; cpu_ram_be = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state and requests before arming
      chk("R1 chan_on", chan_on, 0);
      chk("R1 irq", irq, 0);
      chk("R1 err", err, 0);
      chk("R1 ram_we", ram_we, 0);
      chk("R1 per_we", per_we, 0);
      go();
      chk("R1 unarmed request", c_ram_we, 0);

      // R2 word post-increment, two continuous blocks
      arm(0, 0, 2'b00, 2'b00, 0, 3, 'h40, 0, 5);
      for (int i = 0; i < 8; i++) begin
         per_rdata = 16'h1000 + 16'(i);
         go();
         chk("R2 we", c_ram_we, 1);
         chk("R2 addr", c_addr, 'h40 + 2 * (i % 4));
         chk("R3 word lanes", c_be, 2'b11);
         chk("R2 data", c_wdata, 'h1000 + i);
         chk("R10 block irq", c_irq, (i % 4) == 3);
         chk("R2 stays on", c_on, 1);
      end
      for (int k = 0; k < 4; k++) chk("R2 reload contents", mem[32 + k], 'h1004 + k);

      // R3 byte post-increment
      arm(0, 1, 2'b00, 2'b00, 0, 3, 'h80, 0, 5);
      for (int i = 0; i < 4; i++) begin
         per_rdata = 16'hEE00 | 16'(8'hA0 + i);
         go();
         chk("R3 byte addr", c_addr, 'h80 + i);
         chk("R3 byte lanes", c_be, (i % 2) ? 2'b10 : 2'b01);
      end
      chk("R3 packed lo", mem[64], 'hA1A0);
      chk("R3 packed hi", mem[65], 'hA3A2);

      // R4 RAM to peripheral, word then byte
      arm(1, 0, 2'b00, 2'b00, 0, 3, 'h40, 0, 5);
      for (int i = 0; i < 4; i++) begin
         go();
         chk("R4 per_we", c_per_we, 1);
         chk("R4 no ram_we", c_ram_we, 0);
         chk("R4 word out", c_pdata, 'h1004 + i);
      end
      arm(1, 1, 2'b00, 2'b00, 0, 3, 'h80, 0, 5);
      for (int i = 0; i < 4; i++) begin
         go();
         chk("R4 byte out", c_pdata, 'hA0 + i);
      end

      // R5 fixed address
      arm(0, 0, 2'b01, 2'b00, 0, 2, 'h100, 0, 5);
      for (int i = 0; i < 3; i++) begin
         per_rdata = 16'h2220 + 16'(i);
         go();
         chk("R5 fixed addr", c_addr, 'h100);
         chk("R10 fixed irq", c_irq, i == 2);
      end
      chk("R5 last value", mem['h80], 'h2222);

      // R6 peripheral-indexed, word then byte
      arm(0, 0, 2'b10, 2'b00, 0, 3, 'h200, 0, 5);
      for (int i = 0; i < 4; i++) begin
         per_idx = 4'((i * 3 + 3) % 8);
         go();
         chk("R6 word index", c_addr, 'h200 + 2 * ((i * 3 + 3) % 8));
      end
      arm(0, 1, 2'b10, 2'b00, 0, 3, 'h210, 0, 5);
      for (int i = 0; i < 4; i++) begin
         per_idx = 4'((i * 5 + 9) % 16);
         go();
         chk("R6 byte index", c_addr, 'h210 + ((i * 5 + 9) % 16));
      end

      // R7 one-shot
      arm(0, 0, 2'b00, 2'b01, 0, 1, 'h300, 0, 5);
      go();
      chk("R7 on mid-block", c_on, 1);
      go();
      chk("R7 end irq", c_irq, 1);
      chk("R7 disabled", c_on, 0);
      go();
      chk("R7 no move after end", c_ram_we, 0);
      chk("R7 no irq after end", c_irq, 0);

      // R8 continuous ping-pong
      arm(0, 0, 2'b00, 2'b10, 0, 1, 'h140, 'h180, 5);
      for (int i = 0; i < 6; i++) begin
         go();
         chk("R8 addr", c_addr, ((((i / 2) % 2) != 0) ? 'h180 : 'h140) + 2 * (i % 2));
         chk("R8 buf_act", c_buf, ((i + 1) / 2) % 2);
         chk("R8 irq", c_irq, (i % 2) == 1);
      end

      // R13 one-shot ping-pong
      arm(0, 0, 2'b00, 2'b11, 0, 0, 'h1C0, 'h1E0, 5);
      go();
      chk("R13 buffer A", c_addr, 'h1C0);
      chk("R13 on after A", c_on, 1);
      go();
      chk("R13 buffer B", c_addr, 'h1E0);
      chk("R13 off after B", c_on, 0);
      go();
      chk("R13 stopped", c_ram_we, 0);

      // R9 request line sweep and force
      arm(0, 0, 2'b01, 2'b00, 0, 15, 'h3F0, 0, 17);
      for (int s = 0; s < 32; s++) begin
         xfer(s, 1'b0, 1'b0, 0, 2'b00, 1'b0);
         chk("R9 line select", c_ram_we, s == 17);
      end
      xfer(-1, 1'b1, 1'b0, 0, 2'b00, 1'b0);
      chk("R9 force", c_ram_we, 1);

      // R10 half-block interrupt
      arm(0, 0, 2'b00, 2'b00, 1, 5, 'h240, 0, 5);
      for (int i = 0; i < 12; i++) begin
         go();
         chk("R10 half irq", c_irq, (i % 6) == 2);
      end

      // R11 R12 RAM collision on block-end item
      arm(0, 0, 2'b00, 2'b00, 0, 1, 'h3A0, 0, 5);
      per_rdata = 16'h7700;
      xfer(5, 1'b0, 1'b1, 'h1D2, 2'b11, 1'b0);
      chk("R11 other word no trap", c_ram_we, 1);
      chk("R11 other word err", c_err, 0);
      per_rdata = 16'h7701;
      xfer(5, 1'b0, 1'b1, 'h1D1, 2'b10, 1'b0);
      chk("R11 write dropped", c_ram_we, 0);
      chk("R11 err set", c_err, 1);
      chk("R12 irq held", c_irq, 0);
      chk("R11 halted", c_we3, 0);
      go();
      chk("R11 still halted", c_ram_we, 0);
      chk("R12 no irq in error", c_irq, 0);
      clr_err();
      chk("R11 err cleared", err, 0);
      chk("R11 retry", ram_we, 1);
      chk("R11 retry addr", ram_addr, 'h3A2);
      @(negedge clk);
      chk("R12 irq after retry", irq, 1);
      chk("R11 retried data", mem['h1D1], 'h7701);

      // R11 byte lanes
      arm(0, 1, 2'b00, 2'b00, 0, 3, 'h3B0, 0, 5);
      xfer(5, 1'b0, 1'b1, 'h1D8, 2'b10, 1'b0);
      chk("R11 disjoint lane", c_ram_we, 1);
      chk("R11 disjoint lane err", c_err, 0);
      xfer(5, 1'b0, 1'b1, 'h1D8, 2'b10, 1'b0);
      chk("R11 same lane trap", c_err, 1);
      clr_err();
      chk("R11 lane retry addr", ram_addr, 'h3B1);
      @(negedge clk);

      // R11 peripheral collision
      arm(1, 0, 2'b00, 2'b00, 0, 3, 'h40, 0, 5);
      xfer(5, 1'b0, 1'b0, 0, 2'b00, 1'b1);
      chk("R11 per write dropped", c_per_we, 0);
      chk("R11 per err", c_err, 1);
      clr_err();
      chk("R11 per retry", per_we, 1);
      chk("R11 per retry data", per_wdata, 'h1004);
      @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule